// File: doc/BRIEF.md
# Increment Instruction Decoder

This block decodes one candidate increment instruction whose prefixes, opcode byte and addressing byte have already been separated out by an earlier parsing stage. It identifies the three encodings of the increment operation: the byte form, the full-width form, and the single-byte short register form. For each one it reports the operand width, whether the destination is a register or memory, and which register is the destination. It also flags an instruction that must raise an invalid-opcode fault.

The decode depends on the processor mode. In 64-bit mode the bytes 40h..47h are prefixes and never decode as an increment. A REX prefix can widen the operation to 64 bits, can extend the register index to 8..15, and changes what byte-register indices 4..7 select. The decoder takes one instruction per cycle when `in_valid` is high and presents the result registered, one cycle later. Address calculation and memory faults are handled elsewhere.

Top module: `inc_decoder_top`

## Requirements
- R1: Opcode FEh with ModRM bits [5:3] = 000 decodes as an increment with `op_size` = 00 (8-bit), in either mode.
- R2: Opcode FFh with ModRM bits [5:3] = 000 decodes as an increment with `op_size` = 10 (32-bit), or 01 (16-bit) when `pfx_opsize` is set.
- R3: In 64-bit mode (`mode64`=1), FFh /0 with both `rex_present` and `rex_w` set gives `op_size` = 11 (64-bit), whatever `pfx_opsize` is. In legacy mode the REX inputs are ignored.
- R4: In legacy mode, opcodes 40h..47h decode as an increment with a register destination. The index is taken from opcode bits [2:0], and the width is 32-bit, or 16-bit when `pfx_opsize` is set.
- R5: In 64-bit mode, opcodes 40h..47h give `is_inc`=0 and `ud_fault`=0.
- R6: In 64-bit mode with `rex_present`, `rex_b` supplies `dst_reg[3]` for a register destination. Otherwise `dst_reg[3]` is 0.
- R7: For an 8-bit register destination with index 4..7, `dst_hibyte`=1 (high byte of register index-4) only when no REX prefix is in effect. With REX in 64-bit mode, `dst_hibyte`=0.
- R8: ModRM bits [7:6] = 11 select a register destination (`dst_mem`=0, `dst_reg` from ModRM [2:0]). Any other value selects memory (`dst_mem`=1, `dst_reg`=0).
- R9: `ud_fault`=1 exactly when a decoded increment has `pfx_lock` set and a register destination.
- R10: FEh/FFh with a nonzero ModRM [5:3], and any other opcode (outside the short forms), give all result fields 0, including `ud_fault`.
- R11: Results appear one clock after the inputs, with `out_valid` following `in_valid`. All result fields are 0 while `out_valid`=0 and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decode request this cycle |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = legacy/compatibility |
| pfx_lock | input | 1 | LOCK prefix seen |
| pfx_opsize | input | 1 | Operand-size override prefix seen |
| rex_present | input | 1 | A REX prefix was seen |
| rex_w | input | 1 | REX width bit |
| rex_b | input | 1 | REX register-extension bit for r/m or opcode register |
| opcode | input | 8 | Opcode byte |
| modrm | input | 8 | ModRM byte |
| out_valid | output | 1 | Registered result valid |
| is_inc | output | 1 | Input is an increment |
| op_size | output | 2 | 00=8, 01=16, 10=32, 11=64 bits |
| dst_mem | output | 1 | Destination is memory |
| dst_reg | output | 4 | Destination register index |
| dst_hibyte | output | 1 | Byte destination is a high-byte register |
| ud_fault | output | 1 | Invalid-opcode fault |

## Verification
Several decisions can land in the same result, and the bench drives them together. A LOCK prefix on a register-destination byte increment must raise the fault, and in the same result the REX prefix must decide both the high-byte flag and the extended index. Likewise REX.W and the operand-size override arrive on one FFh instruction, and the 64-bit width must win. Every prefix combination is swept across the opcode and ModRM patterns in both modes, and each registered result is compared with a behavioural model on every clock.

// File: rtl/inc_dec_pkg.sv
// Package: shared types and constants for the increment decoder.
// Assumes opcode and ModRM are byte-wide and the register index is 4 bits.
package inc_dec_pkg;
    localparam int OPC_W      = 8;
    localparam int IDX_W      = 4;
    localparam int LOW_IDX_W  = IDX_W - 1;
    localparam logic [OPC_W-1:0] OPC_BYTE  = 8'hFE;
    localparam logic [OPC_W-1:0] OPC_FULL  = 8'hFF;
    localparam logic [OPC_W-LOW_IDX_W-1:0] SHORT_HI = 5'b01000;
    localparam logic [1:0] MOD_REG = 2'b11;

    typedef enum logic [1:0] {SZ8 = 2'b00, SZ16 = 2'b01, SZ32 = 2'b10, SZ64 = 2'b11} opsz_e;
    typedef enum logic [1:0] {F_NONE, F_SHORT, F_BYTE, F_FULL} form_e;
endpackage

// File: rtl/inc_form_classify.sv
// Module: decides which increment encoding (if any) the opcode/ModRM pair is.
// Assumes mode64 is stable for the cycle; 40h..47h are prefixes in 64-bit mode.
module inc_form_classify
    import inc_dec_pkg::*;
(
    input  logic             mode64,
    input  logic [OPC_W-1:0] opcode,
    input  logic [OPC_W-1:0] modrm,
    output form_e            form
);
    logic reg_field_zero;
    assign reg_field_zero = (modrm[5:3] == 3'd0);

    // Purpose: map the opcode byte onto one of the increment forms.
    always_comb begin
        form = F_NONE;
        if (opcode == OPC_BYTE && reg_field_zero)
            form = F_BYTE;
        else if (opcode == OPC_FULL && reg_field_zero)
            form = F_FULL;
        else if (!mode64 && opcode[OPC_W-1:LOW_IDX_W] == SHORT_HI)
            form = F_SHORT;
    end
endmodule

// File: rtl/inc_size_pick.sv
// Module: picks the operand width for a classified increment.
// Assumes REX inputs are meaningful only in 64-bit mode.
module inc_size_pick
    import inc_dec_pkg::*;
(
    input  form_e mode_form,
    input  logic  mode64,
    input  logic  rex_present,
    input  logic  rex_w,
    input  logic  pfx_opsize,
    output opsz_e size
);
    logic wide;
    assign wide = mode64 && rex_present && rex_w;

    // Purpose: byte form is fixed; others default to 32 with 16/64 overrides.
    always_comb begin
        unique case (mode_form)
            F_BYTE:  size = SZ8;
            F_FULL:  size = wide ? SZ64 : (pfx_opsize ? SZ16 : SZ32);
            F_SHORT: size = pfx_opsize ? SZ16 : SZ32;
            default: size = SZ8;
        endcase
    end
endmodule

// File: rtl/inc_dest_pick.sv
// Module: resolves destination kind, register index and high-byte selection.
// Assumes form is already classified; outputs are zero for F_NONE.
module inc_dest_pick
    import inc_dec_pkg::*;
(
    input  form_e            form,
    input  logic             mode64,
    input  logic             rex_present,
    input  logic             rex_b,
    input  logic [OPC_W-1:0] opcode,
    input  logic [OPC_W-1:0] modrm,
    output logic             dst_mem,
    output logic [IDX_W-1:0] dst_reg,
    output logic             dst_hibyte
);
    logic rex_live;
    assign rex_live = mode64 && rex_present;

    // Purpose: choose memory vs register and build the 4-bit index.
    always_comb begin
        dst_mem    = 1'b0;
        dst_reg    = '0;
        dst_hibyte = 1'b0;
        unique case (form)
            F_SHORT: dst_reg = {1'b0, opcode[LOW_IDX_W-1:0]};
            F_BYTE, F_FULL: begin
                if (modrm[7:6] != MOD_REG) begin
                    dst_mem = 1'b1;
                end else begin
                    dst_reg = {rex_live && rex_b, modrm[LOW_IDX_W-1:0]};
                    dst_hibyte = (form == F_BYTE) && !rex_live && modrm[LOW_IDX_W-1];
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/inc_decoder_top.sv
// Module: increment instruction decoder top; one-cycle registered result.
// Assumes prefix bits are pre-parsed; no memory-side checks are done here.
module inc_decoder_top
    import inc_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             mode64,
    input  logic             pfx_lock,
    input  logic             pfx_opsize,
    input  logic             rex_present,
    input  logic             rex_w,
    input  logic             rex_b,
    input  logic [OPC_W-1:0] opcode,
    input  logic [OPC_W-1:0] modrm,
    output logic             out_valid,
    output logic             is_inc,
    output logic [1:0]       op_size,
    output logic             dst_mem,
    output logic [IDX_W-1:0] dst_reg,
    output logic             dst_hibyte,
    output logic             ud_fault
);
    form_e            form;
    opsz_e            size;
    logic             c_mem, c_hi;
    logic [IDX_W-1:0] c_reg;
    logic             c_inc;

    inc_form_classify u_cls (.mode64(mode64), .opcode(opcode), .modrm(modrm), .form(form));

    inc_size_pick u_size (.mode_form(form), .mode64(mode64), .rex_present(rex_present),
                          .rex_w(rex_w), .pfx_opsize(pfx_opsize), .size(size));

    inc_dest_pick u_dest (.form(form), .mode64(mode64), .rex_present(rex_present),
                          .rex_b(rex_b), .opcode(opcode), .modrm(modrm),
                          .dst_mem(c_mem), .dst_reg(c_reg), .dst_hibyte(c_hi));

    assign c_inc = in_valid && (form != F_NONE);

    // Purpose: register the decode result; clear fields when idle or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            is_inc     <= 1'b0;
            op_size    <= 2'b00;
            dst_mem    <= 1'b0;
            dst_reg    <= '0;
            dst_hibyte <= 1'b0;
            ud_fault   <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            is_inc     <= c_inc;
            op_size    <= c_inc ? size : SZ8;
            dst_mem    <= c_inc && c_mem;
            dst_reg    <= c_inc ? c_reg : '0;
            dst_hibyte <= c_inc && c_hi;
            ud_fault   <= c_inc && pfx_lock && !c_mem;
        end
    end

    // Short-form bytes must never decode in 64-bit mode.
    assert_no_short_in_64_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode64 && opcode[OPC_W-1:LOW_IDX_W] == SHORT_HI) |=> !is_inc && !ud_fault);

    // Width 64 only from a 64-bit mode source cycle.
    assert_wide_needs_64_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_size == 2'b11) |-> ($past(mode64) && $past(rex_present) && is_inc));

    // Fault only on a register-destination increment.
    assert_fault_on_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ud_fault |-> (is_inc && !dst_mem));

    // Extended index needs REX in 64-bit mode.
    assert_ext_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dst_reg[IDX_W-1] |-> ($past(mode64) && $past(rex_present)));

    // High-byte flag only for byte register destinations.
    assert_hibyte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dst_hibyte |-> (op_size == 2'b00 && !dst_mem && is_inc));

    // Idle results are zero.
    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!is_inc && !ud_fault && !dst_mem && dst_reg == '0));
endmodule

// File: tb/sim_inc_decoder_top.sv
module sim_inc_decoder_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, mode64 = 0, pfx_lock = 0, pfx_opsize = 0;
    logic rex_present = 0, rex_w = 0, rex_b = 0;
    logic [7:0] opcode = 0, modrm = 0;
    logic out_valid, is_inc, dst_mem, dst_hibyte, ud_fault;
    logic [1:0] op_size;
    logic [3:0] dst_reg;

    int checks = 0;
    int errors = 0;
    logic [10:0] exp_q;
    string tag_q;

    always #10 clk = ~clk;

    inc_decoder_top u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode64(mode64),
        .pfx_lock(pfx_lock), .pfx_opsize(pfx_opsize), .rex_present(rex_present),
        .rex_w(rex_w), .rex_b(rex_b), .opcode(opcode), .modrm(modrm),
        .out_valid(out_valid), .is_inc(is_inc), .op_size(op_size), .dst_mem(dst_mem),
        .dst_reg(dst_reg), .dst_hibyte(dst_hibyte), .ud_fault(ud_fault));

    // Behavioural reference: returns {valid,inc,size,mem,reg,hi,ud}.
    function automatic logic [10:0] model(input logic v, input logic m64, input logic lk,
        input logic os, input logic rp, input logic rw, input logic rb,
        input int opc, input int mr);
        int sz, r; logic inc, mem, hi, ud;
        int regf = (mr >> 3) & 7;
        bit rex = m64 && rp;
        inc = 0; mem = 0; hi = 0; ud = 0; sz = 0; r = 0;
        if (v) begin
            if ((opc == 'hFE || opc == 'hFF) && regf == 0) begin
                inc = 1;
                if (opc == 'hFE) sz = 0;
                else if (rex && rw) sz = 3;
                else sz = os ? 1 : 2;
                if ((mr >> 6) != 3) mem = 1;
                else begin
                    r = (mr & 7) + ((rex && rb) ? 8 : 0);
                    hi = (opc == 'hFE) && !rex && ((mr & 7) >= 4);
                end
            end else if (!m64 && opc >= 'h40 && opc <= 'h47) begin
                inc = 1; sz = os ? 1 : 2; r = opc - 'h40;
            end
            ud = inc && lk && !mem;
        end
        return {v, inc, sz[1:0], mem, r[3:0], hi, ud};
    endfunction

    function automatic string pick_tag(input logic m64, input logic lk, input logic rp,
        input logic rw, input logic rb, input int opc, input int mr);
        bit full = (opc == 'hFE || opc == 'hFF) && (((mr >> 3) & 7) == 0);
        bit shortf = (opc >= 'h40 && opc <= 'h47);
        bit regd = (mr >> 6) == 3;
        if (shortf) return m64 ? "R5" : "R4";
        if (!full) return "R10";
        if (lk) return "R9";
        if (m64 && rp && rb && regd) return "R6";
        if (opc == 'hFE && regd && (mr & 4)) return "R7";
        if (opc == 'hFF && rw) return "R3";
        if (!regd) return "R8";
        return (opc == 'hFF) ? "R2" : "R1";
    endfunction

    task automatic compare();
        logic [10:0] act;
        act = {out_valid, is_inc, op_size, dst_mem, dst_reg, dst_hibyte, ud_fault};
        checks++;
        if (act !== exp_q) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag_q, act, exp_q);
        end
    endtask

    // Apply at negedge, check the previous stimulus' registered result.
    task automatic step(input logic v, input logic m64, input logic lk, input logic os,
        input logic rp, input logic rw, input logic rb, input int opc, input int mr);
        @(negedge clk);
        compare();
        in_valid = v; mode64 = m64; pfx_lock = lk; pfx_opsize = os;
        rex_present = rp; rex_w = rw; rex_b = rb; opcode = opc[7:0]; modrm = mr[7:0];
        exp_q = model(v, m64, lk, os, rp, rw, rb, opc, mr);
        tag_q = v ? pick_tag(m64, lk, rp, rw, rb, opc, mr) : "R11";
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int opcs[12] = '{'hFE, 'hFF, 'h40, 'h41, 'h43, 'h44, 'h45, 'h47, 'h48, 'h3F, 'h90, 'hFE};
        int mrs[7] = '{'hC0, 'hC4, 'hC7, 'h00, 'h45, 'hC8, 'hF9};
        exp_q = '0; tag_q = "R11";
        repeat (3) @(posedge clk);
        // R11: reset state
        @(negedge clk); compare();
        @(negedge clk); rst_n = 1'b1;
        exp_q = '0; tag_q = "R11";
        for (int m = 0; m < 2; m++)
            for (int o = 0; o < 12; o++)
                for (int k = 0; k < 7; k++)
                    for (int p = 0; p < 32; p++) begin
                        step(1'b1, m[0], p[0], p[1], p[2], p[3], p[4], opcs[o], mrs[k]);
                        if (p == 31) step(1'b0, m[0], 1, 1, 1, 1, 1, 'hFF, 'hC7); // R11 idle
                    end
        step(1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule